// File: doc/BRIEF.md
# Restricted AHB Register-Access Slave Bridge

This block is an AHB slave that turns bus transfers into accesses on a small internal register bus. Up to four register modules sit on that bus. Each one has a one-hot select line, a shared register index, shared write data, and its own ready, error and read-data lines. The bridge accepts only a narrow class of transfers. It forwards each accepted transfer as a single request that is held until the selected module answers. It turns every refusal, module fault or missing answer into the two-cycle AHB ERROR response.

Full address decoding happens outside the block. The bridge looks only at a module field and a register field inside the address. Registers whose index has its top bit set are protected. Writes to them need a privilege input. The bridge also turns three interrupt lines from the modules into single-cycle pulses.

Top module: `ahb_regbridge`

## Requirements
- R1: Only word transfers (hsize = 3'b010) are forwarded. An active transfer of any other size gets an ERROR response and raises no internal request.
- R2: An active transfer with hmastlock high gets an ERROR response and raises no internal request.
- R3: Address bits [15:10] hold a module number, and values 0 to 3 drive the matching bit of rb_sel. Address bits [9:2] drive rb_idx. Address bits [1:0], hburst and hprot have no effect, so a burst is served as a string of single accesses.
- R4: A module number of 4 or more gets an ERROR response and raises no internal request.
- R5: If the selected module answers with its error line instead of its ready line, the transfer ends with ERROR.
- R6: The request is held for at most 16 cycles. Ready seen in the 16th cycle completes the transfer normally. If there is still no answer after 16 cycles, the request drops and the transfer ends with ERROR.
- R7: A register whose index has bit 7 set accepts writes only while su_en is high during the address phase. Otherwise the write gets ERROR and the register keeps its value. Reads of such registers need no privilege.
- R8: hresp is only OKAY (2'b00) or ERROR (2'b01). An ERROR is always one cycle with hready_out low, followed by one cycle with hready_out high.
- R9: IDLE (2'b00) or BUSY (2'b01) transfers, and any transfer with hsel low, get a zero-wait OKAY and raise no internal request.
- R10: Take a module that raises ready in the L-th cycle of the request (L counted from 0, at most 15). The transfer then holds hready_out low for L+2 cycles and then completes with OKAY. On a read, the module's word appears on hrdata in the completion cycle. On a write, hwdata is carried on rb_wdata.
- R11: Each rising edge of an irq_src line gives exactly one cycle of high on the matching irq_pulse line, in the cycle after the edge is sampled.
- R12: While rst is high: hready_out is high, hresp is OKAY, rb_req is low and irq_pulse is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hsel | input | 1 | Slave select |
| haddr | input | 32 | Transfer address |
| htrans | input | 2 | Transfer type |
| hwrite | input | 1 | Write when high |
| hsize | input | 3 | Transfer size |
| hburst | input | 3 | Burst type (not decoded) |
| hprot | input | 4 | Protection type (not decoded) |
| hmastlock | input | 1 | Locked transfer |
| hready_in | input | 1 | Bus ready seen by all slaves |
| hwdata | input | 32 | Write data |
| su_en | input | 1 | Privilege for protected registers |
| hready_out | output | 1 | Registered slave ready |
| hresp | output | 2 | Registered response |
| hrdata | output | 32 | Registered read data |
| rb_req | output | 1 | Internal request, held until answered or timed out |
| rb_wr | output | 1 | Internal write when high |
| rb_sel | output | 4 | One-hot module select |
| rb_idx | output | 8 | Register index |
| rb_wdata | output | 32 | Internal write data |
| rb_rdy | input | 4 | Per-module ready |
| rb_err | input | 4 | Per-module error |
| rb_rdata | input | 128 | Per-module read data, module m at bits [32m+31:32m] |
| irq_src | input | 3 | Module interrupt lines |
| irq_pulse | output | 3 | Single-cycle interrupt pulses |

## Verification
The assertions assume that hready_in follows hready_out, as it does when this is the only slave in use. They assume the master keeps hwdata steady while the transfer is stalled. They also assume each module raises ready or error only while it is selected and the request is high, and never both at once. The bench stub answers only the one-hot selected module, and only at one chosen cycle of the request. The bench drives every bus input half a cycle away from the sampling edge and feeds hready_out straight back to hready_in. That keeps the stimulus inside these assumptions, including back-to-back transfers that start during the second ERROR cycle.

// File: rtl/ahbrb_pkg.sv
package ahbrb_pkg;

    localparam int unsigned DW       = 32;
    localparam int unsigned AW       = 32;
    localparam int unsigned NMOD     = 4;
    localparam int unsigned SEL_LSB  = 10;
    localparam int unsigned SEL_W    = 6;
    localparam int unsigned IDX_LSB  = 2;
    localparam int unsigned IDX_W    = 8;
    localparam int unsigned NIRQ     = 3;

    localparam logic [2:0] SZ_WORD = 3'b010;

    typedef enum logic [1:0] {
        RSP_OKAY  = 2'b00,
        RSP_ERROR = 2'b01,
        RSP_RETRY = 2'b10,
        RSP_SPLIT = 2'b11
    } hresp_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_DATA,
        S_WAIT,
        S_ERR1,
        S_ERR2
    } state_e;

    typedef struct packed {
        logic             active;
        logic             fault;
        logic             wr;
        logic [NMOD-1:0]  sel;
        logic [IDX_W-1:0] idx;
    } dec_t;

    function automatic logic [NMOD-1:0] mod_onehot(input logic [SEL_W-1:0] num);
        logic [NMOD-1:0] oh;
        oh = '0;
        for (int i = 0; i < NMOD; i++) begin
            if (num == SEL_W'(i)) oh[i] = 1'b1;
        end
        return oh;
    endfunction

endpackage

// File: rtl/ahbrb_decode.sv
module ahbrb_decode
    import ahbrb_pkg::*;
#(
    parameter int unsigned PROT_BIT = 7
) (
    input  logic          hsel,
    input  logic [1:0]    htrans,
    input  logic          hwrite,
    input  logic [2:0]    hsize,
    input  logic          hmastlock,
    input  logic [AW-1:0] haddr,
    input  logic          su_en,
    output dec_t          dec
);

    logic [SEL_W-1:0] mod_num;
    logic [NMOD-1:0]  mod_oh;
    logic             unmapped;
    logic             bad_size;
    logic             priv_miss;
    logic             unused_addr;

    assign mod_num   = haddr[SEL_LSB +: SEL_W];
    assign mod_oh    = mod_onehot(mod_num);
    assign unmapped  = (mod_oh == '0);
    assign bad_size  = (hsize != SZ_WORD);
    assign priv_miss = hwrite && haddr[IDX_LSB + PROT_BIT] && !su_en;

    assign unused_addr = ^{haddr[AW-1:SEL_LSB+SEL_W], haddr[IDX_LSB-1:0]};

    always_comb begin
        dec.active = hsel && htrans[1];
        dec.fault  = bad_size || hmastlock || unmapped || priv_miss;
        dec.wr     = hwrite;
        dec.sel    = mod_oh;
        dec.idx    = haddr[IDX_LSB +: IDX_W];
    end

endmodule

// File: rtl/ahbrb_seq.sv
module ahbrb_seq
    import ahbrb_pkg::*;
#(
    parameter int unsigned TIMEOUT = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               hready_in,
    input  dec_t               dec,
    input  logic [DW-1:0]      hwdata,
    output logic               hready_out,
    output logic [1:0]         hresp,
    output logic [DW-1:0]      hrdata,
    output logic               rb_req,
    output logic               rb_wr,
    output logic [NMOD-1:0]    rb_sel,
    output logic [IDX_W-1:0]   rb_idx,
    output logic [DW-1:0]      rb_wdata,
    input  logic [NMOD-1:0]    rb_rdy,
    input  logic [NMOD-1:0]    rb_err,
    input  logic [NMOD*DW-1:0] rb_rdata
);

    localparam int unsigned CW = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;

    state_e           st;
    hresp_e           resp_q;
    logic             hready_q;
    logic [DW-1:0]    rdata_q;
    logic             req_q;
    logic             wr_q;
    logic [NMOD-1:0]  sel_q;
    logic [IDX_W-1:0] idx_q;
    logic [DW-1:0]    wdata_q;
    logic [CW-1:0]    cnt;

    logic             take;
    logic             hit;
    logic             fail;
    logic             expired;
    logic [DW-1:0]    lane;

    assign take    = hready_in && dec.active;
    assign hit     = |(rb_rdy & sel_q);
    assign fail    = |(rb_err & sel_q);
    assign expired = (cnt == CW'(TIMEOUT - 1));

    always_comb begin
        lane = '0;
        for (int i = 0; i < NMOD; i++) begin
            if (sel_q[i]) lane = lane | rb_rdata[i*DW +: DW];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= S_IDLE;
            hready_q <= 1'b1;
            resp_q   <= RSP_OKAY;
            rdata_q  <= '0;
            req_q    <= 1'b0;
            wr_q     <= 1'b0;
            sel_q    <= '0;
            idx_q    <= '0;
            wdata_q  <= '0;
            cnt      <= '0;
        end else begin
            rdata_q <= '0;
            unique case (st)
                S_IDLE, S_ERR2: begin
                    if (take && dec.fault) begin
                        st       <= S_ERR1;
                        hready_q <= 1'b0;
                        resp_q   <= RSP_ERROR;
                    end else if (take) begin
                        st       <= S_DATA;
                        hready_q <= 1'b0;
                        resp_q   <= RSP_OKAY;
                        sel_q    <= dec.sel;
                        idx_q    <= dec.idx;
                        wr_q     <= dec.wr;
                    end else begin
                        st       <= S_IDLE;
                        hready_q <= 1'b1;
                        resp_q   <= RSP_OKAY;
                    end
                end
                S_DATA: begin
                    wdata_q <= wr_q ? hwdata : '0;
                    req_q   <= 1'b1;
                    cnt     <= '0;
                    st      <= S_WAIT;
                end
                S_WAIT: begin
                    if (fail) begin
                        req_q  <= 1'b0;
                        resp_q <= RSP_ERROR;
                        st     <= S_ERR1;
                    end else if (hit) begin
                        req_q    <= 1'b0;
                        hready_q <= 1'b1;
                        resp_q   <= RSP_OKAY;
                        rdata_q  <= wr_q ? '0 : lane;
                        st       <= S_IDLE;
                    end else if (expired) begin
                        req_q  <= 1'b0;
                        resp_q <= RSP_ERROR;
                        st     <= S_ERR1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                S_ERR1: begin
                    hready_q <= 1'b1;
                    resp_q   <= RSP_ERROR;
                    st       <= S_ERR2;
                end
                default: begin
                    st       <= S_IDLE;
                    hready_q <= 1'b1;
                    resp_q   <= RSP_OKAY;
                    req_q    <= 1'b0;
                end
            endcase
        end
    end

    assign hready_out = hready_q;
    assign hresp      = resp_q;
    assign hrdata     = rdata_q;
    assign rb_req     = req_q;
    assign rb_wr      = wr_q;
    assign rb_sel     = sel_q;
    assign rb_idx     = idx_q;
    assign rb_wdata   = wdata_q;

    logic [CW:0] run_len;
    always_ff @(posedge clk) begin
        if (rst)         run_len <= '0;
        else if (req_q)  run_len <= run_len + 1'b1;
        else             run_len <= '0;
    end

    // R6: a request never stays up longer than the timeout window
    a_r6_req_bounded: assert property (@(posedge clk) disable iff (rst)
        run_len <= (CW+1)'(TIMEOUT));

    // R3: a live request always names exactly one module
    a_r3_sel_onehot: assert property (@(posedge clk) disable iff (rst)
        rb_req |-> $onehot(rb_sel));

    // R10: the bus is stalled while the internal request is up
    a_r10_stall_on_req: assert property (@(posedge clk) disable iff (rst)
        rb_req |-> !hready_out);

    // R8: first ERROR cycle is followed by the ready ERROR cycle
    a_r8_err_second: assert property (@(posedge clk) disable iff (rst)
        (hresp == RSP_ERROR && !hready_out) |=> (hresp == RSP_ERROR && hready_out));

    // R8: a ready ERROR cycle always follows a stalled ERROR cycle
    a_r8_err_first: assert property (@(posedge clk) disable iff (rst)
        (hresp == RSP_ERROR && hready_out) |-> $past(hresp == RSP_ERROR && !hready_out));

endmodule

// File: rtl/ahbrb_irq.sv
module ahbrb_irq
    import ahbrb_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NIRQ-1:0] src,
    output logic [NIRQ-1:0] pulse
);

    logic [NIRQ-1:0] prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev  <= '0;
            pulse <= '0;
        end else begin
            prev  <= src;
            pulse <= src & ~prev;
        end
    end

    for (genvar g = 0; g < NIRQ; g++) begin : g_chk
        // R11: a pulse never lasts two cycles
        a_r11_single: assert property (@(posedge clk) disable iff (rst)
            pulse[g] |=> !pulse[g]);
    end

endmodule

// File: rtl/ahb_regbridge.sv
module ahb_regbridge
    import ahbrb_pkg::*;
#(
    parameter int unsigned TIMEOUT  = 16,
    parameter int unsigned PROT_BIT = 7
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               hsel,
    input  logic [AW-1:0]      haddr,
    input  logic [1:0]         htrans,
    input  logic               hwrite,
    input  logic [2:0]         hsize,
    input  logic [2:0]         hburst,
    input  logic [3:0]         hprot,
    input  logic               hmastlock,
    input  logic               hready_in,
    input  logic [DW-1:0]      hwdata,
    input  logic               su_en,
    output logic               hready_out,
    output logic [1:0]         hresp,
    output logic [DW-1:0]      hrdata,
    output logic               rb_req,
    output logic               rb_wr,
    output logic [NMOD-1:0]    rb_sel,
    output logic [IDX_W-1:0]   rb_idx,
    output logic [DW-1:0]      rb_wdata,
    input  logic [NMOD-1:0]    rb_rdy,
    input  logic [NMOD-1:0]    rb_err,
    input  logic [NMOD*DW-1:0] rb_rdata,
    input  logic [NIRQ-1:0]    irq_src,
    output logic [NIRQ-1:0]    irq_pulse
);

    dec_t dec;
    logic unused_ctrl;

    assign unused_ctrl = ^{hburst, hprot};

    ahbrb_decode #(.PROT_BIT(PROT_BIT)) u_decode (
        .hsel      (hsel),
        .htrans    (htrans),
        .hwrite    (hwrite),
        .hsize     (hsize),
        .hmastlock (hmastlock),
        .haddr     (haddr),
        .su_en     (su_en),
        .dec       (dec)
    );

    ahbrb_seq #(.TIMEOUT(TIMEOUT)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .hready_in  (hready_in),
        .dec        (dec),
        .hwdata     (hwdata),
        .hready_out (hready_out),
        .hresp      (hresp),
        .hrdata     (hrdata),
        .rb_req     (rb_req),
        .rb_wr      (rb_wr),
        .rb_sel     (rb_sel),
        .rb_idx     (rb_idx),
        .rb_wdata   (rb_wdata),
        .rb_rdy     (rb_rdy),
        .rb_err     (rb_err),
        .rb_rdata   (rb_rdata)
    );

    ahbrb_irq u_irq (
        .clk   (clk),
        .rst   (rst),
        .src   (irq_src),
        .pulse (irq_pulse)
    );

    // R1: an accepted non-word transfer starts the ERROR sequence
    a_r1_size_err: assert property (@(posedge clk) disable iff (rst)
        (hsel && htrans[1] && hready_in && hready_out && hsize != SZ_WORD)
        |=> (hresp == RSP_ERROR && !hready_out));

    // R2: an accepted locked transfer starts the ERROR sequence
    a_r2_lock_err: assert property (@(posedge clk) disable iff (rst)
        (hsel && htrans[1] && hready_in && hready_out && hmastlock)
        |=> (hresp == RSP_ERROR && !hready_out));

    // R9: no transfer in the address phase keeps the bus at zero wait OKAY
    a_r9_idle_okay: assert property (@(posedge clk) disable iff (rst)
        (hready_in && hready_out && !(hsel && htrans[1]))
        |=> (hready_out && hresp == RSP_OKAY));

    // R8: SPLIT and RETRY are never returned
    a_r8_no_split: assert property (@(posedge clk) disable iff (rst)
        hresp[1] == 1'b0);

endmodule

// File: tb/test_ahb_regbridge.sv
module test_ahb_regbridge;

    localparam int NM = 4;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst;
    logic          hsel;
    logic [31:0]   haddr;
    logic [1:0]    htrans;
    logic          hwrite;
    logic [2:0]    hsize;
    logic [2:0]    hburst;
    logic [3:0]    hprot;
    logic          hmastlock;
    logic          hready_in;
    logic [31:0]   hwdata;
    logic          su_en;
    logic          hready_out;
    logic [1:0]    hresp;
    logic [31:0]   hrdata;
    logic          rb_req;
    logic          rb_wr;
    logic [3:0]    rb_sel;
    logic [7:0]    rb_idx;
    logic [31:0]   rb_wdata;
    logic [3:0]    rb_rdy;
    logic [3:0]    rb_err;
    logic [127:0]  rb_rdata;
    logic [2:0]    irq_src;
    logic [2:0]    irq_pulse;

    assign hready_in = hready_out;

    ahb_regbridge i_ahb_regbridge (
        .clk(clk), .rst(rst), .hsel(hsel), .haddr(haddr), .htrans(htrans),
        .hwrite(hwrite), .hsize(hsize), .hburst(hburst), .hprot(hprot),
        .hmastlock(hmastlock), .hready_in(hready_in), .hwdata(hwdata),
        .su_en(su_en), .hready_out(hready_out), .hresp(hresp), .hrdata(hrdata),
        .rb_req(rb_req), .rb_wr(rb_wr), .rb_sel(rb_sel), .rb_idx(rb_idx),
        .rb_wdata(rb_wdata), .rb_rdy(rb_rdy), .rb_err(rb_err),
        .rb_rdata(rb_rdata), .irq_src(irq_src), .irq_pulse(irq_pulse)
    );

    int total = 0;
    int bad = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    // register module stubs
    logic [31:0] mem [NM][256];
    int  stub_lat = 0;
    bit  stub_err = 0;
    int  age = 0;
    int  req_rises = 0;
    logic req_d = 1'b0;

    function automatic int sel_num(input logic [3:0] s);
        for (int m = 0; m < NM; m++) if (s[m]) return m;
        return 0;
    endfunction

    always @(posedge clk) begin
        req_d <= rb_req;
        if (rb_req && !req_d) req_rises <= req_rises + 1;
        if (!rb_req) age <= 0;
        else         age <= age + 1;
        if (rb_req && age == stub_lat && !stub_err && rb_wr)
            mem[sel_num(rb_sel)][rb_idx] <= rb_wdata;
    end

    always_comb begin
        rb_rdy = '0;
        rb_err = '0;
        if (rb_req && age == stub_lat) begin
            if (stub_err) rb_err = rb_sel;
            else          rb_rdy = rb_sel;
        end
    end

    always_comb begin
        for (int m = 0; m < NM; m++) rb_rdata[m*32 +: 32] = mem[m][rb_idx];
    end

    int resp_bad = 0;
    always @(negedge clk) if (!rst && hresp[1]) resp_bad <= resp_bad + 1;

    function automatic logic [31:0] mk(input int md, input int idx, input int lo);
        return {16'h0000, 6'(md), 8'(idx), 2'(lo)};
    endfunction

    // One transfer; returns at the falling edge inside its last cycle.
    task automatic xfer(input logic [31:0] a, input bit wr, input logic [2:0] sz,
                        input bit lk, input bit pv, input logic [1:0] tr, input bit sl,
                        input logic [31:0] wd, input int n_low, input bit e_err,
                        input bit rd_chk, input logic [31:0] rd_exp, input string rq);
        hsel = sl; haddr = a; hwrite = wr; hsize = sz; hmastlock = lk;
        su_en = pv; htrans = tr;
        @(posedge clk);
        @(negedge clk);
        htrans = 2'b00; hsel = 1'b0; hmastlock = 1'b0; hwdata = wd;
        for (int i = 0; i < n_low; i++) begin
            chk(!hready_out && hresp == 2'b00, rq, {29'd0, hready_out, hresp}, 32'h0);
            @(negedge clk);
        end
        if (e_err) begin
            chk(!hready_out && hresp == 2'b01, rq, {29'd0, hready_out, hresp}, 32'h1);
            @(negedge clk);
            chk(hready_out && hresp == 2'b01, rq, {29'd0, hready_out, hresp}, 32'h5);
        end else begin
            chk(hready_out && hresp == 2'b00, rq, {29'd0, hready_out, hresp}, 32'h4);
            if (rd_chk) chk(hrdata == rd_exp, rq, hrdata, rd_exp);
        end
    endtask

    task automatic wr_ok(input logic [31:0] a, input logic [31:0] wd, input int lat, input string rq);
        stub_lat = lat; stub_err = 0;
        xfer(a, 1, 3'b010, 0, 0, 2'b10, 1, wd, lat + 2, 0, 0, 0, rq);
    endtask

    task automatic rd_ok(input logic [31:0] a, input logic [31:0] ex, input int lat, input string rq);
        stub_lat = lat; stub_err = 0;
        xfer(a, 0, 3'b010, 0, 0, 2'b10, 1, 32'h0, lat + 2, 0, 1, ex, rq);
    endtask

    initial begin
        #2000000;
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int rr;
        for (int m = 0; m < NM; m++)
            for (int i = 0; i < 256; i++) mem[m][i] = 32'h0;
        rst = 1; hsel = 0; haddr = 0; htrans = 0; hwrite = 0; hsize = 3'b010;
        hburst = 0; hprot = 0; hmastlock = 0; hwdata = 0; su_en = 0; irq_src = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(hready_out && hresp == 2'b00 && !rb_req && irq_pulse == 3'b000, "R12 reset",
            {26'd0, hready_out, hresp, irq_pulse}, 32'h20);
        rst = 0;
        @(negedge clk);

        // R3 / R10: each module, varying latency, low address bits set on write
        for (int m = 0; m < NM; m++) wr_ok(mk(m, 5, 3), 32'hA000_0000 + m, m, "R10 write");
        for (int m = 0; m < NM; m++) rd_ok(mk(m, 5, 0), 32'hA000_0000 + m, 0, "R3 decode read");
        wr_ok(mk(2, 8'h3C, 0), 32'h1234_5678, 1, "R10 write");
        rd_ok(mk(2, 8'h3C, 2), 32'h1234_5678, 15, "R10 latency 15");

        // R6: no answer in 16 cycles
        stub_lat = 16; stub_err = 0;
        xfer(mk(1, 9, 0), 1, 3'b010, 0, 0, 2'b10, 1, 32'hDEAD_BEEF, 17, 1, 0, 0, "R6 timeout");
        rd_ok(mk(1, 9, 0), 32'h0, 0, "R6 write dropped");

        // R5: module error
        stub_lat = 3; stub_err = 1;
        xfer(mk(3, 5, 0), 0, 3'b010, 0, 0, 2'b10, 1, 32'h0, 5, 1, 0, 0, "R5 module error");

        // R1 / R2 / R4: refused in the address phase, back to back
        rr = req_rises;
        xfer(mk(0, 5, 0), 0, 3'b000, 0, 0, 2'b10, 1, 32'h0, 0, 1, 0, 0, "R1 byte size");
        xfer(mk(0, 5, 0), 1, 3'b001, 0, 0, 2'b10, 1, 32'h0, 0, 1, 0, 0, "R1 half size");
        xfer(mk(0, 5, 0), 0, 3'b010, 1, 0, 2'b10, 1, 32'h0, 0, 1, 0, 0, "R2 locked");
        xfer(mk(4, 5, 0), 0, 3'b010, 0, 0, 2'b10, 1, 32'h0, 0, 1, 0, 0, "R4 module 4");
        xfer(mk(63, 5, 0), 1, 3'b010, 0, 0, 2'b10, 1, 32'h0, 0, 1, 0, 0, "R4 module 63");
        chk(req_rises == rr, "R4 no request", req_rises, rr);
        rd_ok(mk(0, 5, 0), 32'hA000_0000, 0, "R1 after error");

        // R7: protected registers
        stub_lat = 0; stub_err = 0;
        xfer(mk(1, 8'h80, 0), 1, 3'b010, 0, 1, 2'b10, 1, 32'h5555_0001, 2, 0, 0, 0, "R7 priv write");
        xfer(mk(1, 8'h80, 0), 1, 3'b010, 0, 0, 2'b10, 1, 32'h6666_0002, 0, 1, 0, 0, "R7 unpriv write");
        rd_ok(mk(1, 8'h80, 0), 32'h5555_0001, 2, "R7 unpriv read");
        wr_ok(mk(1, 8'h7F, 0), 32'h7777_0003, 0, "R7 open write");
        rd_ok(mk(1, 8'h7F, 0), 32'h7777_0003, 0, "R7 open read");

        // R9: no-transfer cases
        rr = req_rises;
        xfer(mk(0, 1, 0), 1, 3'b010, 0, 0, 2'b00, 1, 32'h0, 0, 0, 0, 0, "R9 idle");
        xfer(mk(0, 1, 0), 1, 3'b010, 0, 0, 2'b01, 1, 32'h0, 0, 0, 0, 0, "R9 busy");
        xfer(mk(0, 1, 0), 1, 3'b010, 0, 0, 2'b10, 0, 32'h0, 0, 0, 0, 0, "R9 unselected");
        @(negedge clk);
        chk(req_rises == rr, "R9 no request", req_rises, rr);
        rd_ok(mk(0, 1, 0), 32'h0, 0, "R9 register untouched");

        // R3: burst with hburst/hprot set, sequential transfers
        hburst = 3'b001; hprot = 4'hF;
        stub_lat = 0; stub_err = 0;
        xfer(mk(3, 16, 0), 1, 3'b010, 0, 0, 2'b10, 1, 32'hB0, 2, 0, 0, 0, "R3 burst first");
        xfer(mk(3, 17, 0), 1, 3'b010, 0, 0, 2'b11, 1, 32'hB1, 2, 0, 0, 0, "R3 burst seq");
        xfer(mk(3, 18, 0), 1, 3'b010, 0, 0, 2'b11, 1, 32'hB2, 2, 0, 0, 0, "R3 burst seq");
        hburst = 0; hprot = 0;
        rd_ok(mk(3, 17, 0), 32'hB1, 0, "R3 burst readback");
        rd_ok(mk(3, 18, 0), 32'hB2, 0, "R3 burst readback");

        // R11: interrupt pulses
        for (int k = 0; k < 3; k++) begin
            int seen;
            seen = 0;
            irq_src[k] = 1'b1;
            @(negedge clk);
            chk(irq_pulse == (3'b001 << k), "R11 pulse cycle", irq_pulse, 3'b001 << k);
            for (int c = 0; c < 4; c++) begin
                @(negedge clk);
                if (irq_pulse != 0) seen++;
            end
            chk(seen == 0, "R11 single cycle", seen, 0);
            irq_src[k] = 1'b0;
            @(negedge clk);
            chk(irq_pulse == 0, "R11 falling edge", irq_pulse, 0);
        end

        chk(resp_bad == 0, "R8 only okay/error", resp_bad, 0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule